// File: doc/BRIEF.md
# Display Memory Host Access Port with Byte Holder

This block connects a host command stream to a pixel memory of 81 rows by 132 columns. The rows form ten pages of eight lines, each stored as one byte per column, plus an eleventh icon page that holds a single line in bit 0. The block keeps a 4-bit page register and a column counter. It turns host commands into RAM address, write-enable, read-enable and write-data strobes. In normal display a stored 1 leaves the pixel dark and a stored 0 lights it. The block only moves the bits and never looks at their meaning.

All host traffic passes through a one-byte holder. A write goes to the RAM at the current column, and the written byte is left in the holder. A read hands back whatever the holder contains and then refills the holder from the current column. Data from the RAM therefore reaches the host one read later than it is addressed, so the first read after any address change is a dummy read. The RAM answers a read strobe with data one cycle later.

Commands arrive on a valid/ready stream, and a command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. Read results leave on a second valid/ready stream. A result stays on `rd_data` until the host raises `rd_ready`. While a result is held back, the command stream is stalled. The command stream is also stalled for the single cycle in which the holder refills after a read.

Top module: `disp_ram_access`

## Requirements
- R1: After reset the page and column are 0, the holder holds 0x00, `rd_valid`, `ram_we` and `ram_re` are low and `cmd_ready` is high. The first read after reset therefore returns 0x00.
- R2: `cmd_op` encodes the command: 2'b00 sets the page, 2'b01 sets the column, 2'b10 writes, 2'b11 reads. `cmd_ready` is low in the cycle after a read is accepted.
- R3: A page set loads `cmd_arg[3:0]` into the page register, ignoring the upper bits. No other command changes the page.
- R4: A column set loads `cmd_arg`. Values above 131 are clamped to 131.
- R5: An accepted write on a valid page raises `ram_we` in the same cycle, with `ram_page`/`ram_col` at the current address and the byte on `ram_wdata`. The column then advances by one.
- R6: Writes and reads advance the column only up to 131. At 131 the column stays at 131.
- R7: An accepted read returns the current holder byte on `rd_data` (with `rd_valid`) in the next cycle. It also raises `ram_re` at the current address and advances the column. The RAM byte arriving one cycle later becomes the new holder content.
- R8: A page set or a column set clears the holder to 0x00. The first read after either one returns 0x00, and the second read returns the byte at the set address.
- R9: Page 10 is the icon page. Write data to it is sent with bits 7..1 forced to 0, and bytes read from it keep only bit 0.
- R10: Pages 11 to 15 never raise `ram_we` or `ram_re`. A read there loads 0x00 into the holder. The column still advances.
- R11: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_data` does not change.
- R12: A write leaves the byte it sent (masked as in R9) in the holder, so a read straight after a write returns that byte. This holds on every page, including pages 11 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | Command code (see R2) |
| cmd_arg | input | 8 | Page, column or write byte |
| rd_valid | output | 1 | Read result present |
| rd_ready | input | 1 | Host takes the read result |
| rd_data | output | 8 | Read result byte |
| ram_page | output | 4 | RAM page address |
| ram_col | output | 8 | RAM column address |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe; data expected next cycle |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, one cycle after `ram_re` |

## Verification
The bench targets the dummy read after both kinds of address set, the read that directly follows a write, and the column stuck at 131 after a clamped set. A design that refilled the holder before answering would return the addressed byte one read too early. A design that wrapped the column would write to column 0. On the icon page the bench preloads a RAM byte with its upper bits set, which exposes a missing read mask or write mask. Pages 11 to 15 are checked for stray strobes. A random `rd_ready` pattern tests whether a held result changes under back-pressure or a command slips in during the refill cycle.

// File: rtl/disp_ram_pkg.sv
`timescale 1ns/1ps
package disp_ram_pkg;
  localparam int unsigned DR_COLS  = 132;
  localparam int unsigned DR_PAGES = 11;
  localparam int unsigned DR_DW    = 8;
  localparam int unsigned DR_PW    = 4;

  typedef enum logic [1:0] {
    OP_PAGE  = 2'b00,
    OP_COL   = 2'b01,
    OP_WRITE = 2'b10,
    OP_READ  = 2'b11
  } dr_op_e;
endpackage

// File: rtl/dr_lane_mask.sv
`timescale 1ns/1ps
module dr_lane_mask #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] din,
  input  logic          low_only,
  input  logic          zero_all,
  output logic [DW-1:0] dout
);
  for (genvar b = 0; b < DW; b++) begin : g_lane
    if (b == 0) begin : g_keep
      assign dout[b] = din[b] & ~zero_all;
    end else begin : g_drop
      assign dout[b] = din[b] & ~low_only & ~zero_all;
    end
  end
endmodule

// File: rtl/dr_addr_ctrl.sv
`timescale 1ns/1ps
module dr_addr_ctrl #(
  parameter int unsigned COLS  = 132,
  parameter int unsigned PAGES = 11,
  parameter int unsigned DW    = 8,
  parameter int unsigned PW    = 4,
  parameter int unsigned CW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_page,
  input  logic          set_col,
  input  logic          advance,
  input  logic [DW-1:0] arg,
  output logic [PW-1:0] page_q,
  output logic [CW-1:0] col_q,
  output logic          page_ok,
  output logic          on_icon
);
  localparam logic [PW-1:0] ICON_PG = PW'(PAGES - 1);
  localparam logic [DW-1:0] LAST_D  = DW'(COLS - 1);
  localparam logic [CW-1:0] LAST_C  = CW'(COLS - 1);

  logic [CW-1:0] col_set_v;
  assign col_set_v = (arg > LAST_D) ? LAST_C : arg[CW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        page_q <= '0;
    else if (set_page) page_q <= arg[PW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        col_q <= '0;
    else if (set_col)                  col_q <= col_set_v;
    else if (advance && col_q != LAST_C) col_q <= col_q + CW'(1);
  end

  assign page_ok = (page_q <= ICON_PG);
  assign on_icon = (page_q == ICON_PG);

  // R3: page only moves on a page set
  a_r3_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !set_page |=> $stable(page_q));
  // R5: column steps by one on an access below the last column
  a_r5_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !set_col && col_q != LAST_C) |=> col_q == $past(col_q) + CW'(1));
  // R6: column stays at the last column
  a_r6_col_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !set_col && col_q == LAST_C) |=> col_q == LAST_C);
  // R4: column never exceeds the last column
  a_r4_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= LAST_C);
endmodule

// File: rtl/dr_holder.sv
`timescale 1ns/1ps
module dr_holder #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load_wr,
  input  logic [DW-1:0] wr_byte,
  input  logic          issue_rd,
  input  logic          issue_ok,
  input  logic          issue_icon,
  input  logic [DW-1:0] ram_rdata,
  output logic [DW-1:0] holder_q,
  output logic          busy
);
  logic          fetch_q, fetch_ok_q, fetch_icon_q;
  logic [DW-1:0] fetch_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q      <= 1'b0;
      fetch_ok_q   <= 1'b0;
      fetch_icon_q <= 1'b0;
    end else begin
      fetch_q      <= issue_rd;
      fetch_ok_q   <= issue_ok;
      fetch_icon_q <= issue_icon;
    end
  end

  dr_lane_mask #(.DW(DW)) u_rmask (
    .din      (ram_rdata),
    .low_only (fetch_icon_q),
    .zero_all (!fetch_ok_q),
    .dout     (fetch_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       holder_q <= '0;
    else if (clear)   holder_q <= '0;
    else if (load_wr) holder_q <= wr_byte;
    else if (fetch_q) holder_q <= fetch_byte;
  end

  assign busy = fetch_q;

  // R8: an address set empties the holder
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> holder_q == '0);
  // R12: a write leaves its byte in the holder
  a_r12_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (load_wr && !clear) |=> holder_q == $past(wr_byte));
  // R10: refill from an invalid page is zero
  a_r10_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_rd && !issue_ok) |=> ##1 holder_q == '0);
endmodule

// File: rtl/dr_rd_resp.sv
`timescale 1ns/1ps
module dr_rd_resp #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          stall
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (load) begin
      rd_valid <= 1'b1;
      rd_data  <= din;
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  assign stall = rd_valid && !rd_ready;

  // R11: a refused result is held unchanged
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: rtl/disp_ram_access.sv
`timescale 1ns/1ps
module disp_ram_access
  import disp_ram_pkg::*;
#(
  parameter int unsigned COLS  = DR_COLS,
  parameter int unsigned PAGES = DR_PAGES,
  parameter int unsigned DW    = DR_DW,
  parameter int unsigned PW    = DR_PW,
  localparam int unsigned CW   = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_arg,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic [PW-1:0] ram_page,
  output logic [CW-1:0] ram_col,
  output logic          ram_we,
  output logic          ram_re,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata
);
  localparam logic [PW-1:0] ICON_PG = PW'(PAGES - 1);

  logic          accept, acc_page, acc_col, acc_wr, acc_rd;
  logic [PW-1:0] page_q;
  logic [CW-1:0] col_q;
  logic          page_ok, on_icon;
  logic [DW-1:0] wr_byte, holder_q;
  logic          fetch_busy, resp_stall;

  assign accept   = cmd_valid && cmd_ready;
  assign acc_page = accept && (cmd_op == OP_PAGE);
  assign acc_col  = accept && (cmd_op == OP_COL);
  assign acc_wr   = accept && (cmd_op == OP_WRITE);
  assign acc_rd   = accept && (cmd_op == OP_READ);

  dr_addr_ctrl #(.COLS(COLS), .PAGES(PAGES), .DW(DW), .PW(PW), .CW(CW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_page (acc_page),
    .set_col  (acc_col),
    .advance  (acc_wr || acc_rd),
    .arg      (cmd_arg),
    .page_q   (page_q),
    .col_q    (col_q),
    .page_ok  (page_ok),
    .on_icon  (on_icon)
  );

  dr_lane_mask #(.DW(DW)) u_wmask (
    .din      (cmd_arg),
    .low_only (on_icon),
    .zero_all (1'b0),
    .dout     (wr_byte)
  );

  dr_holder #(.DW(DW)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (acc_page || acc_col),
    .load_wr    (acc_wr),
    .wr_byte    (wr_byte),
    .issue_rd   (acc_rd),
    .issue_ok   (page_ok),
    .issue_icon (on_icon),
    .ram_rdata  (ram_rdata),
    .holder_q   (holder_q),
    .busy       (fetch_busy)
  );

  dr_rd_resp #(.DW(DW)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (acc_rd),
    .din      (holder_q),
    .rd_ready (rd_ready),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .stall    (resp_stall)
  );

  assign cmd_ready = !fetch_busy && !resp_stall;
  assign ram_page  = page_q;
  assign ram_col   = col_q;
  assign ram_we    = acc_wr && page_ok;
  assign ram_re    = acc_rd && page_ok;
  assign ram_wdata = wr_byte;

  // R2: no command taken during the refill cycle
  a_r2_refill_stall: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> !cmd_ready);
  // R10: no RAM strobe outside the valid pages
  a_r10_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || ram_re) |-> ram_page <= ICON_PG);
  // R9: icon writes carry only bit 0
  a_r9_icon_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ram_page == ICON_PG) |-> ram_wdata[DW-1:1] == '0);
  // R7: a read yields a result in the next cycle
  a_r7_resp: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rd_valid);
endmodule

// File: tb/sim_disp_ram_access.sv
`timescale 1ns/1ps
module sim_disp_ram_access;
  localparam int PAGES = 11, COLS = 132, ICON = 10, LAST = 131;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_arg = 8'h00;
  logic       rd_valid, rd_ready = 1'b1;
  logic [7:0] rd_data;
  logic [3:0] ram_page;
  logic [7:0] ram_col;
  logic       ram_we, ram_re;
  logic [7:0] ram_wdata;
  logic [7:0] ram_rdata = 8'h00;

  disp_ram_access u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_arg(cmd_arg), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .ram_page(ram_page), .ram_col(ram_col), .ram_we(ram_we),
    .ram_re(ram_re), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // bench RAM, one cycle read latency
  logic [7:0] bmem [0:PAGES-1][0:COLS-1];
  always @(posedge clk) begin
    if (ram_we && ram_page < PAGES) bmem[ram_page][ram_col] <= ram_wdata;
    if (ram_re && ram_page < PAGES) ram_rdata <= bmem[ram_page][ram_col];
  end

  // reference model state
  int    smem [0:PAGES-1][0:COLS-1];
  int    m_page = 0, m_col = 0, m_hold = 0;
  string m_why = "R1";
  bit    after_pset = 0, after_clamp = 0;
  int    exp_rd[$];
  string exp_tag[$];
  bit    exp_we = 0, exp_re = 0;
  int    exp_pg = 0, exp_cl = 0, exp_wd = 0;
  string exp_wtag = "R5";
  bit    bp_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, expv);
    end
  endtask

  task automatic model_apply(int op, int arg);
    bit ok;
    int d;
    ok = (m_page <= ICON);
    case (op)
      0: begin m_page = arg & 15; m_hold = 0; m_why = "R8"; after_pset = 1; end
      1: begin
        m_col = (arg > LAST) ? LAST : arg; m_hold = 0; m_why = "R8";
        after_clamp = (arg > LAST);
      end
      2: begin
        d = (m_page == ICON) ? (arg & 1) : arg;
        if (ok) begin
          exp_we = 1; exp_pg = m_page; exp_cl = m_col; exp_wd = d;
          smem[m_page][m_col] = d;
          if (m_page == ICON) exp_wtag = "R9";
          else if (after_clamp) exp_wtag = "R4";
          else if (m_col == LAST) exp_wtag = "R6";
          else if (after_pset) exp_wtag = "R3";
          else exp_wtag = "R5";
        end
        m_hold = d; m_why = "R12";
        after_pset = 0; after_clamp = 0;
        if (m_col < LAST) m_col++;
      end
      default: begin
        exp_rd.push_back(m_hold); exp_tag.push_back(m_why);
        if (ok) begin
          exp_re = 1; exp_pg = m_page; exp_cl = m_col;
          m_hold = smem[m_page][m_col] & ((m_page == ICON) ? 1 : 255);
          m_why = (m_page == ICON) ? "R9" : (m_col == LAST) ? "R6" : "R7";
        end else begin
          m_hold = 0; m_why = "R10";
        end
        after_pset = 0; after_clamp = 0;
        if (m_col < LAST) m_col++;
      end
    endcase
  endtask

  task automatic send(int op, int arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_arg = arg[7:0];
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    model_apply(op, arg);
    @(posedge clk); #0.5;
    cmd_valid = 1'b0;
    if (op == 3) begin
      @(negedge clk); #1;
      chk(cmd_ready === 1'b0, "R2", "cmd_ready in refill cycle", int'(cmd_ready), 0);
    end
  endtask

  // back-pressure pattern
  initial forever begin
    @(negedge clk);
    rd_ready = bp_mode ? lfsr[0] : 1'b1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  // per-cycle comparison
  bit         prev_stall = 0;
  logic [7:0] prev_data = 8'h00;
  initial forever begin
    @(negedge clk); #1.5;
    if (rst_n) begin
      chk(ram_we === exp_we, exp_we ? exp_wtag : "R10", "ram_we", int'(ram_we), int'(exp_we));
      chk(ram_re === exp_re, exp_re ? "R7" : "R10", "ram_re", int'(ram_re), int'(exp_re));
      if (exp_we && ram_we) begin
        chk(ram_page == exp_pg, exp_wtag, "write page", int'(ram_page), exp_pg);
        chk(ram_col == exp_cl, exp_wtag, "write column", int'(ram_col), exp_cl);
        chk(ram_wdata == exp_wd, exp_wtag, "write byte", int'(ram_wdata), exp_wd);
      end
      if (exp_re && ram_re) begin
        chk(ram_page == exp_pg, "R7", "read page", int'(ram_page), exp_pg);
        chk(ram_col == exp_cl, "R7", "read column", int'(ram_col), exp_cl);
      end
      if (prev_stall) begin
        chk(rd_valid === 1'b1, "R11", "rd_valid held", int'(rd_valid), 1);
        chk(rd_data == prev_data, "R11", "rd_data held", int'(rd_data), int'(prev_data));
      end
      if (rd_valid && rd_ready) begin
        if (exp_rd.size() == 0) chk(0, "R7", "unexpected read result", int'(rd_data), -1);
        else begin
          int e; string t;
          e = exp_rd.pop_front(); t = exp_tag.pop_front();
          chk(rd_data == e[7:0], t, "read result", int'(rd_data), e);
        end
      end
      prev_stall = rd_valid && !rd_ready;
      prev_data  = rd_data;
    end
    exp_we = 0; exp_re = 0;
  end

  initial begin
    for (int p = 0; p < PAGES; p++)
      for (int c = 0; c < COLS; c++) begin bmem[p][c] = 8'h00; smem[p][c] = 0; end
    bmem[ICON][5] = 8'hAB; smem[ICON][5] = 171;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(cmd_ready === 1'b1, "R1", "cmd_ready after reset", int'(cmd_ready), 1);
    chk(rd_valid === 1'b0, "R1", "rd_valid after reset", int'(rd_valid), 0);
    chk(ram_we === 1'b0 && ram_re === 1'b0, "R1", "strobes after reset", int'({ram_we, ram_re}), 0);
    chk(ram_page == 0 && ram_col == 0, "R1", "address after reset", int'({ram_page, ram_col}), 0);

    send(3, 0);                                   // R1 first read gives 0x00
    send(0, 8'h12); send(1, 5);                   // R3 page 2 via low nibble
    send(2, 8'hA5); send(2, 8'h3C); send(2, 8'h0F);
    send(3, 0);                                   // R12 returns 0x0F
    send(1, 5);
    send(3, 0); send(3, 0); send(3, 0); send(3, 0); // R8 dummy then R7 data

    send(1, 200);                                 // R4 clamp to 131
    send(2, 8'h11); send(2, 8'h22);               // R6 second write stays at 131
    send(1, 130);
    send(3, 0); send(3, 0); send(3, 0); send(3, 0); send(3, 0);

    send(0, 10); send(1, 0);                      // R9 icon page
    send(2, 8'hFE); send(2, 8'h03);
    send(1, 0); send(3, 0); send(3, 0); send(3, 0);
    send(1, 5); send(3, 0); send(3, 0);

    send(0, 12); send(1, 3);                      // R10 invalid page
    send(2, 8'h55); send(3, 0); send(3, 0); send(3, 0);
    send(0, 2); send(1, 3); send(3, 0); send(3, 0);

    send(0, 3); send(1, 0);                       // R11 back-pressure run
    for (int i = 0; i < 40; i++) send(2, (i * 37 + 5) & 255);
    bp_mode = 1;
    send(1, 0);
    for (int i = 0; i < 41; i++) send(3, 0);
    send(0, 7); send(1, 0); send(3, 0); send(3, 0);
    bp_mode = 0;
    repeat (6) @(negedge clk);
    #2;
    chk(exp_rd.size() == 0, "R7", "results outstanding", exp_rd.size(), 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R2 watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule